// File: doc/BRIEF.md
# Hashed Page Table Index Hash Unit

This unit turns a virtual page number into the primary hash that selects a page-table entry group in a hashed page table. The virtual page number is the virtual address with its 12 byte-offset bits removed. The unit takes three inputs with each request: that number, a segment-size code and a page-size shift. It returns a 39-bit primary hash and a 39-bit secondary hash. The secondary hash is the bitwise complement of the primary one and indexes the alternate group. The unit also returns an error flag for requests it cannot hash.

The two segment sizes mix bits differently. With 256 MB segments, the segment identifier is the part of the page number above bit 16. It is XORed with the page index inside the segment. With 1 TB segments, the segment identifier is the part above bit 28. It is first XORed with a copy of itself shifted left by 25 bits, and then the page index is XORed in. In both cases the page index is the in-segment part of the page number, shifted right by the page shift minus 12.

The result sits in one pipeline register behind a valid/ready handshake. The register is a two-state controller with these transitions:
- EMPTY goes to FULL when a request arrives (`load`).
- FULL stays FULL when the consumer takes the result and a new request arrives in the same cycle (`reload`).
- FULL stays FULL while the consumer stalls (`hold`).
- FULL returns to EMPTY when the consumer takes the result and no request arrives (`drain`).

Top module: `hpt_hash_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For segment code 0 (256 MB), the primary hash is `(vpn >> 16) ^ ((vpn mod 2^16) >> (pshift-12))`, truncated to 39 bits.
- R3: For segment code 1 (1 TB), with `v = vpn >> 28`, the primary hash is `v ^ (v << 25) ^ ((vpn mod 2^28) >> (pshift-12))`, truncated to 39 bits.
- R4: The page index moves with the page shift. At a page shift equal to the segment shift (28 or 40), the page index contributes nothing.
- R5: Only bits 38:0 of the mixed value reach the output. Identifier bits above bit 38 never appear.
- R6: Segment codes 2 and 3 are reserved. They set `out_err` to 1 and force both hash outputs to 0.
- R7: A page shift below 12, or above the segment shift (28 for code 0, 40 for code 1), sets `out_err` and forces both hash outputs to 0. The boundary values 12, 28 and 40 are accepted.
- R8: When `out_err` is 0, `out_hash_sec` equals the 39-bit complement of `out_hash`.
- R9: A request accepted on a clock edge (`in_valid` and `in_ready` both 1) appears with `out_valid` set after that edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outputs stay unchanged and `in_ready` is 0.
- R11: When the result is taken and no request arrives, `out_valid` drops after the edge. When a request arrives in the same cycle, the result is replaced with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_vpn | input | 66 | Virtual page number (address >> 12) |
| in_seg | input | 2 | Segment size: 0 = 256 MB, 1 = 1 TB, 2/3 reserved |
| in_pshift | input | 6 | Page-size shift in bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hash | output | 39 | Primary hash |
| out_hash_sec | output | 39 | Secondary hash (complement of primary) |
| out_err | output | 1 | Request was not hashable |

## Verification
The bench goes after the page-shift boundaries: 11/12, 28/29 for 256 MB segments and 40/41 for 1 TB segments.
- An off-by-one range check either flags a legal shift or lets an illegal shift produce a shifted-out index.
- If the segment sizes are swapped or the 25-bit self-mix is dropped, the 1 TB hashes come out wrong.
- If bit 39 is not masked off, high identifier bits leak into the output.

The handshake is driven through stall, reload and drain sequences:
- A register that loads while stalled overwrites a held result.
- A `drain` that does not clear the valid flag repeats the last result.

// File: rtl/hpt_hash_pkg.sv
package hpt_hash_pkg;
    localparam int VPN_W      = 66;
    localparam int HASH_W     = 39;
    localparam int SHIFT_W    = 6;
    localparam int BASE_SHIFT = 12;
    localparam int SEG_S_BITS = 28;
    localparam int SEG_L_BITS = 40;
    localparam int MIX_SHIFT  = 25;

    typedef enum logic [1:0] {
        SEG_256M = 2'd0,
        SEG_1T   = 2'd1
    } seg_code_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_e;
endpackage

// File: rtl/hpt_hash_core.sv
module hpt_hash_core
    import hpt_hash_pkg::*;
#(
    parameter int VW  = VPN_W,
    parameter int HW  = HASH_W,
    parameter int SW  = SHIFT_W,
    parameter int BS  = BASE_SHIFT,
    parameter int SSB = SEG_S_BITS,
    parameter int SLB = SEG_L_BITS,
    parameter int MX  = MIX_SHIFT,
    parameter bit SEC_EN = 1'b1
) (
    input  logic [VW-1:0] vpn,
    input  logic [1:0]    seg,
    input  logic [SW-1:0] pshift,
    output logic [HW-1:0] hash,
    output logic [HW-1:0] hash_sec,
    output logic          err
);
    localparam int IDX_S = SSB - BS;
    localparam int IDX_L = SLB - BS;
    localparam logic [VW-1:0] MASK_S = {{(VW-IDX_S){1'b0}}, {IDX_S{1'b1}}};
    localparam logic [VW-1:0] MASK_L = {{(VW-IDX_L){1'b0}}, {IDX_L{1'b1}}};

    logic [SW-1:0] shamt;
    logic [VW-1:0] vsid_s, vsid_l, idx_s, idx_l, mix_s, mix_l;

    always_comb begin
        shamt  = pshift - SW'(BS);
        vsid_s = vpn >> IDX_S;
        vsid_l = vpn >> IDX_L;
        idx_s  = (vpn & MASK_S) >> shamt;
        idx_l  = (vpn & MASK_L) >> shamt;
        mix_s  = vsid_s ^ idx_s;
        mix_l  = vsid_l ^ (vsid_l << MX) ^ idx_l;
        err    = 1'b0;
        hash   = '0;
        unique case (seg)
            SEG_256M: begin
                err  = (pshift < SW'(BS)) || (pshift > SW'(SSB));
                hash = err ? '0 : mix_s[HW-1:0];
            end
            SEG_1T: begin
                err  = (pshift < SW'(BS)) || (pshift > SW'(SLB));
                hash = err ? '0 : mix_l[HW-1:0];
            end
            default: begin
                err  = 1'b1;
                hash = '0;
            end
        endcase
    end

    generate
        if (SEC_EN) begin : g_sec
            assign hash_sec = err ? '0 : ~hash;
        end else begin : g_nosec
            assign hash_sec = '0;
        end
    endgenerate
endmodule

// File: rtl/hpt_hash_stage.sv
module hpt_hash_stage
    import hpt_hash_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    stage_st_e state, state_nxt;
    logic      take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (in_valid) state_nxt = ST_FULL;                 // load
            ST_FULL:  if (out_ready && !in_valid) state_nxt = ST_EMPTY;  // drain
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state == ST_FULL);
        in_ready  = (state == ST_EMPTY) || out_ready;
        take      = in_valid && in_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_data <= '0;
        else if (take) out_data <= in_data;
    end
endmodule

// File: rtl/hpt_hash_unit.sv
module hpt_hash_unit
    import hpt_hash_pkg::*;
#(
    parameter bit SEC_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [VPN_W-1:0]    in_vpn,
    input  logic [1:0]          in_seg,
    input  logic [SHIFT_W-1:0]  in_pshift,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [HASH_W-1:0]   out_hash,
    output logic [HASH_W-1:0]   out_hash_sec,
    output logic                out_err
);
    localparam int PW = 1 + 2 * HASH_W;

    logic [HASH_W-1:0] c_hash, c_sec;
    logic              c_err;
    logic [PW-1:0]     s_data;

    hpt_hash_core #(.SEC_EN(SEC_EN)) u_core (
        .vpn      (in_vpn),
        .seg      (in_seg),
        .pshift   (in_pshift),
        .hash     (c_hash),
        .hash_sec (c_sec),
        .err      (c_err)
    );

    hpt_hash_stage #(.W(PW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   ({c_err, c_sec, c_hash}),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (s_data)
    );

    assign out_hash     = s_data[HASH_W-1:0];
    assign out_hash_sec = s_data[2*HASH_W-1:HASH_W];
    assign out_err      = s_data[PW-1];
endmodule

// File: rtl/hpt_hash_unit_chk.sv
module hpt_hash_unit_chk
    import hpt_hash_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [VPN_W-1:0]   in_vpn,
    input logic [1:0]         in_seg,
    input logic [SHIFT_W-1:0] in_pshift,
    input logic               out_valid,
    input logic               out_ready,
    input logic [HASH_W-1:0]  out_hash,
    input logic [HASH_W-1:0]  out_hash_sec,
    input logic               out_err
);
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);                                          // R9
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_hash) && $stable(out_err)); // R10
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);                                       // R10
    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);                          // R11
    AST_RESERVED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_seg[1] |=> out_err && out_hash == '0);             // R6
    AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_hash == '0 && out_hash_sec == '0);               // R7
    AST_SEC_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_err |-> out_hash_sec == ~out_hash);                         // R8
endmodule

bind hpt_hash_unit hpt_hash_unit_chk u_chk (.*);

// File: tb/hpt_hash_unit_tb.sv
`timescale 1ns/1ps
module hpt_hash_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [65:0] in_vpn = '0;
    logic [1:0]  in_seg = '0;
    logic [5:0]  in_pshift = 6'd12;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [38:0] out_hash, out_hash_sec;
    logic        out_err;

    int checks = 0;
    int failures = 0;

    logic        m_valid = 1'b0;
    logic [38:0] m_hash = '0, m_sec = '0;
    logic        m_err = 1'b0;

    always #2 clk = ~clk;

    hpt_hash_unit u_dut (.*);

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void ref_calc(input logic [65:0] vpn, input logic [1:0] seg, input int ps,
                                     output logic [38:0] h, output logic [38:0] s, output logic e);
        logic [127:0] v, idx, full;
        int segsh;
        e = 1'b0; h = '0; s = '0;
        if (seg == 2'd0) segsh = 28;
        else if (seg == 2'd1) segsh = 40;
        else begin e = 1'b1; return; end
        if (ps < 12 || ps > segsh) begin e = 1'b1; return; end
        v   = 128'(vpn) / (128'd1 << (segsh - 12));
        idx = (128'(vpn) % (128'd1 << (segsh - 12))) / (128'd1 << (ps - 12));
        if (seg == 2'd1) full = v ^ (v * (128'd1 << 25)) ^ idx;
        else             full = v ^ idx;
        h = full[38:0];
        s = ~h;
    endfunction

    // one cycle: drive, predict the edge, compare after it
    task automatic step(input string tag, input logic v, input logic [65:0] vpn,
                        input logic [1:0] seg, input int ps, input logic ordy);
        logic exp_rdy;
        logic [38:0] h, s;
        logic e;
        @(negedge clk);
        in_valid = v; in_vpn = vpn; in_seg = seg; in_pshift = 6'(ps); out_ready = ordy;
        #1;
        exp_rdy = !m_valid || ordy;
        chk({tag, " in_ready R10"}, 80'(in_ready), 80'(exp_rdy));
        if (v && exp_rdy) begin
            ref_calc(vpn, seg, ps, h, s, e);
            m_valid = 1'b1; m_hash = h; m_sec = s; m_err = e;
        end else if (m_valid && ordy) begin
            m_valid = 1'b0;
        end
        @(posedge clk);
        #1;
        chk({tag, " out_valid R9 R11"}, 80'(out_valid), 80'(m_valid));
        if (m_valid) begin
            chk({tag, " hash"}, 80'(out_hash), 80'(m_hash));
            chk({tag, " sec R8"}, 80'(out_hash_sec), 80'(m_sec));
            chk({tag, " err"}, 80'(out_err), 80'(m_err));
        end
    endtask

    task automatic req(input string tag, input logic [65:0] vpn, input logic [1:0] seg, input int ps);
        step(tag, 1'b1, vpn, seg, ps, 1'b1);
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [65:0] r;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid", 80'(out_valid), 80'(0));
        chk("R1 in_ready", 80'(in_ready), 80'(1));
        @(negedge clk);
        rst_n = 1'b1;

        // hand-worked values
        req("R2 fixed", 66'h3_0001, 2'd0, 12);
        chk("R2 fixed value", 80'(out_hash), 80'h2);
        req("R3 fixed", 66'h1000_0000, 2'd1, 12);
        chk("R3 fixed value", 80'(out_hash), 80'h200_0001);

        for (int i = 0; i < 40; i++) begin
            r = {$urandom, $urandom, $urandom};
            req("R2 rand", r, 2'd0, 12 + (i % 17));
            req("R3 rand", r, 2'd1, 12 + (i % 29));
        end
        // R4 page index vanishes at the segment shift
        req("R4 256M ps28", 66'h5_FFFF, 2'd0, 28);
        chk("R4 256M ps28 value", 80'(out_hash), 80'h5);
        req("R4 1T ps40", 66'h7_0FFF_FFFF, 2'd1, 40);
        req("R4 256M ps16", 66'h0_1234, 2'd0, 16);
        // R5 truncation
        req("R5 ones 256M", '1, 2'd0, 12);
        req("R5 ones 1T", '1, 2'd1, 12);
        req("R5 topbit 256M", 66'h1 << 60, 2'd0, 12);
        chk("R5 topbit value", 80'(out_hash), 80'h0);
        // R6 reserved codes
        req("R6 seg2", 66'h1234_5678, 2'd2, 12);
        chk("R6 seg2 err", 80'(out_err), 80'(1));
        req("R6 seg3", 66'h1234_5678, 2'd3, 20);
        // R7 shift range
        req("R7 ps11", 66'h9_9999, 2'd0, 11);
        chk("R7 ps11 err", 80'(out_err), 80'(1));
        req("R7 ps12", 66'h9_9999, 2'd0, 12);
        req("R7 ps29", 66'h9_9999, 2'd0, 29);
        req("R7 ps40 1T", 66'h9_9999_9999, 2'd1, 40);
        req("R7 ps41 1T", 66'h9_9999_9999, 2'd1, 41);
        chk("R7 ps41 err", 80'(out_err), 80'(1));
        req("R7 ps0 1T", 66'h9_9999_9999, 2'd1, 0);
        // R10 stall with competing requests
        step("R10 load", 1'b1, 66'hABC_DEF0, 2'd1, 16, 1'b0);
        for (int i = 0; i < 4; i++) step("R10 hold", 1'b1, 66'h1111 * (i + 1), 2'd0, 12, 1'b0);
        // R11 reload then drain
        step("R11 reload", 1'b1, 66'h42_0042, 2'd0, 14, 1'b1);
        step("R11 drain", 1'b0, '0, 2'd0, 12, 1'b1);
        step("R11 idle", 1'b0, '0, 2'd0, 12, 1'b1);
        for (int i = 0; i < 6; i++) step("R11 stream", 1'b1, 66'h777 << i, 2'(i % 2), 12 + i, (i % 3) != 1);
        step("R11 tail", 1'b0, '0, 2'd0, 12, 1'b1);
        step("R11 tail2", 1'b0, '0, 2'd0, 12, 1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule